// File: doc/BRIEF.md
# Bus Cycle Termination and Line-Burst Controller

This block is the master-side sequencer for one cycle on a 32-bit processor bus. A requester hands it either a single long-word access or a four-beat line read or write. The block raises a one-cycle transfer-start strobe with the address, then watches the slave's acknowledge inputs on each data clock. Those inputs are a normal acknowledge, a retry request, an error, a burst inhibit and a cache inhibit. From them it decides how the cycle ends: completion, retry or bus error.

Accepted beats are reported one at a time, each with its beat index and a cacheable flag. When a slave refuses a burst on its first beat, the controller breaks the rest of the line into three single long-word cycles and reports that break. A mode input selects between two acknowledge conventions. In native mode a dedicated retry input exists. In legacy mode a retry is encoded as error plus acknowledge on the first transfer.

Top module: `bus_term_ctrl`

## Requirements
- R1: While reset is held and after it is released with no request, `busy`, `bus_start`, `beat_valid`, `cyc_done`, `cyc_retry`, `cyc_error` and `burst_split` are all 0.
- R2: A request taken in idle produces, one clock later, exactly one clock of `bus_start`. During it `bus_addr` equals the request address and `bus_burst` equals `req_line`. The data phase follows on the next clock.
- R3: With `legacy_ack`=0, a data clock with `ack_err`=1 ends the cycle as a bus error whatever the other inputs are. Otherwise `ack_retry`=1 on a first transfer gives a retry. Otherwise `ack_ok`=1 accepts the beat.
- R4: `ack_retry` is acted on only on the first transfer of a bus cycle. On later beats of a burst it has no effect, and the beat is judged on `ack_err` and `ack_ok` alone.
- R5: A retry gives a one-clock `cyc_retry`. On the next clock `bus_start` is raised again with the same address. The cycle restarts from beat index 0.
- R6: With `legacy_ack`=1, `ack_retry` is ignored. `ack_err` and `ack_ok` together on a first transfer give a retry. On any later beat, the same pair gives a bus error, as does `ack_err` alone.
- R7: A bus error gives a one-clock `cyc_error`. The controller returns to idle with no further `bus_start`.
- R8: A line access reports four accepted beats with `beat_idx` 0, 1, 2, 3. A single access reports one beat with index 0. `cyc_done` is high together with the last beat, and `busy` is 0 on the next clock.
- R9: `ack_noburst`=1 with an accepted first beat of a burst line raises `burst_split` for that beat. The controller then runs three single cycles, each with its own `bus_start` and with `bus_burst`=0. For k = 1 to 3, `bus_addr` = {addr[31:4], (addr[3:2]+k) mod 4, addr[1:0]}. `ack_noburst` is ignored at every other time.
- R10: For line reads, `beat_cacheable` on every beat is the inverse of `ack_nocache` as sampled on beat 0. `ack_nocache` on later beats is ignored. Writes and single accesses report `beat_cacheable`=0.
- R11: A data clock with neither `ack_ok` nor `ack_err` (and no honoured retry) is a wait state. It reports nothing and keeps the cycle open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| legacy_ack | input | 1 | 1 = legacy acknowledge encoding, 0 = native |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_line | input | 1 | 1 = four-beat line access, 0 = single long word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request byte address |
| busy | output | 1 | A cycle is in progress |
| bus_start | output | 1 | Transfer start strobe |
| bus_addr | output | 32 | Address of the current bus cycle |
| bus_burst | output | 1 | Current bus cycle is a burst |
| bus_write | output | 1 | Current bus cycle is a write |
| ack_ok | input | 1 | Slave normal acknowledge |
| ack_retry | input | 1 | Slave retry request |
| ack_err | input | 1 | Slave error |
| ack_noburst | input | 1 | Slave cannot burst |
| ack_nocache | input | 1 | Slave marks line data non-cacheable |
| beat_valid | output | 1 | A data beat was accepted this clock |
| beat_idx | output | 2 | Index of the accepted beat within the line |
| beat_cacheable | output | 1 | Accepted beat may be cached |
| cyc_done | output | 1 | Access completed this clock |
| cyc_retry | output | 1 | Access is being retried |
| cyc_error | output | 1 | Access ended with a bus error |
| burst_split | output | 1 | Burst refused; rest of line goes as single cycles |

## Verification
The hardest situations to reach are the interactions of a retry with position: a retry pattern on a later burst beat, and an error-plus-acknowledge pair that means retry on beat 0 but error on beat 1. The bench reaches them by running a full line for every one of the 32 acknowledge patterns on the first data clock. It then repeats with the pattern held back to the second beat, in both modes. Follow-on single cycles after a burst refusal are driven with burst-inhibit and cache-inhibit still asserted, which shows that both are ignored there.

// File: rtl/bct_pkg.sv
package bct_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA} bct_state_e;
  typedef enum logic [1:0] {TM_NONE, TM_OK, TM_RETRY, TM_ERR} bct_term_e;
endpackage

// File: rtl/bct_rst_sync.sv
module bct_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/bct_term_decode.sv
module bct_term_decode
  import bct_pkg::*;
(
  input  logic      legacy,
  input  logic      first,
  input  logic      ok,
  input  logic      rty,
  input  logic      err,
  output bct_term_e term
);
  always_comb begin
    term = TM_NONE;
    if (!legacy) begin
      // native: error over retry over acknowledge
      if (err)              term = TM_ERR;
      else if (rty && first) term = TM_RETRY;
      else if (ok)          term = TM_OK;
    end else begin
      // legacy: retry input unused, error+ack on first transfer means retry
      if (err && ok && first) term = TM_RETRY;
      else if (err)           term = TM_ERR;
      else if (ok)            term = TM_OK;
    end
  end
endmodule

// File: rtl/bct_beat_track.sv
module bct_beat_track #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic             cache_ld,
  input  logic             cache_d,
  output logic [CNT_W-1:0] cnt,
  output logic             cache_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (adv) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cache_q <= 1'b0;
    else if (cache_ld) cache_q <= cache_d;
  end
endmodule

// File: rtl/bus_term_ctrl.sv
module bus_term_ctrl
  import bct_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BEATS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          legacy_ack,
  input  logic                          req_valid,
  input  logic                          req_line,
  input  logic                          req_write,
  input  logic [ADDR_W-1:0]             req_addr,
  output logic                          busy,
  output logic                          bus_start,
  output logic [ADDR_W-1:0]             bus_addr,
  output logic                          bus_burst,
  output logic                          bus_write,
  input  logic                          ack_ok,
  input  logic                          ack_retry,
  input  logic                          ack_err,
  input  logic                          ack_noburst,
  input  logic                          ack_nocache,
  output logic                          beat_valid,
  output logic [$clog2(LINE_BEATS)-1:0] beat_idx,
  output logic                          beat_cacheable,
  output logic                          cyc_done,
  output logic                          cyc_retry,
  output logic                          cyc_error,
  output logic                          burst_split
);
  localparam int CNT_W  = $clog2(LINE_BEATS);
  localparam int OFS_LO = 2;
  localparam int OFS_HI = OFS_LO + CNT_W - 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(LINE_BEATS - 1);

  logic rst_n_i;
  bct_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  bct_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic line_q, write_q, split_q, split_d;
  logic addr_ld, cnt_clr, cnt_adv, cache_ld, cache_q;
  logic [CNT_W-1:0] cnt, ofs;
  logic burst_act, first, in_data, last, brk;
  logic acc_ok, acc_retry, acc_err;
  bct_term_e term;

  assign burst_act = line_q && !split_q;
  assign first     = !burst_act || (cnt == '0);
  assign in_data   = (state_q == ST_DATA);
  assign last      = !line_q || (cnt == LAST_IDX);

  bct_term_decode u_dec (
    .legacy (legacy_ack),
    .first  (first),
    .ok     (ack_ok),
    .rty    (ack_retry),
    .err    (ack_err),
    .term   (term)
  );

  assign acc_ok    = in_data && (term == TM_OK);
  assign acc_retry = in_data && (term == TM_RETRY);
  assign acc_err   = in_data && (term == TM_ERR);
  assign brk       = acc_ok && burst_act && (cnt == '0) && ack_noburst;
  assign cache_ld  = acc_ok && line_q && (cnt == '0);

  bct_beat_track #(.CNT_W(CNT_W)) u_beat (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .clr      (cnt_clr),
    .adv      (cnt_adv),
    .cache_ld (cache_ld),
    .cache_d  (!write_q && !ack_nocache),
    .cnt      (cnt),
    .cache_q  (cache_q)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    split_d = split_q;
    addr_ld = 1'b0;
    cnt_clr = 1'b0;
    cnt_adv = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_ADDR;
          addr_ld = 1'b1;
          cnt_clr = 1'b1;
          split_d = 1'b0;
        end
      end
      ST_ADDR: state_d = ST_DATA;
      ST_DATA: begin
        if (acc_err) begin
          state_d = ST_IDLE;
        end else if (acc_retry) begin
          state_d = ST_ADDR;
        end else if (acc_ok) begin
          cnt_adv = !last;
          if (last) begin
            state_d = ST_IDLE;
          end else if (brk || split_q) begin
            state_d = ST_ADDR;
            split_d = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_IDLE;
      split_q <= 1'b0;
    end else begin
      state_q <= state_d;
      split_q <= split_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      addr_q  <= '0;
      line_q  <= 1'b0;
      write_q <= 1'b0;
    end else if (addr_ld) begin
      addr_q  <= req_addr;
      line_q  <= req_line;
      write_q <= req_write;
    end
  end

  assign ofs       = addr_q[OFS_HI:OFS_LO] + cnt;
  assign bus_addr  = {addr_q[ADDR_W-1:OFS_HI+1], ofs, addr_q[OFS_LO-1:0]};
  assign busy      = (state_q != ST_IDLE);
  assign bus_start = (state_q == ST_ADDR);
  assign bus_burst = burst_act;
  assign bus_write = write_q;

  assign beat_valid     = acc_ok;
  assign beat_idx       = cnt;
  assign beat_cacheable = acc_ok && line_q && !write_q &&
                          ((cnt == '0) ? !ack_nocache : cache_q);
  assign cyc_done       = acc_ok && last;
  assign cyc_retry      = acc_retry;
  assign cyc_error      = acc_err;
  assign burst_split    = brk;
endmodule

// File: rtl/bus_term_ctrl_chk.sv
module bus_term_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              bus_start,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_burst,
  input logic              bus_write,
  input logic              beat_valid,
  input logic [CNT_W-1:0]  beat_idx,
  input logic              beat_cacheable,
  input logic              cyc_done,
  input logic              cyc_retry,
  input logic              cyc_error,
  input logic              burst_split
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cyc_done, cyc_retry, cyc_error})); // R3
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> !bus_start); // R2
  AST_LATE_NO_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_burst && beat_idx != '0) |-> !cyc_retry); // R4
  AST_RETRY_RERUN: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_retry |=> (bus_start && bus_addr == $past(bus_addr))); // R5
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_error |=> (!busy && !bus_start)); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !busy); // R8
  AST_SPLIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    burst_split |-> (beat_valid && beat_idx == '0)); // R9
  AST_SPLIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    burst_split |=> (bus_start && !bus_burst)); // R9
  AST_WRITE_NOCACHE: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && bus_write) |-> !beat_cacheable); // R10
endmodule

bind bus_term_ctrl bus_term_ctrl_chk #(.ADDR_W(ADDR_W), .CNT_W($clog2(LINE_BEATS))) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .busy           (busy),
  .bus_start      (bus_start),
  .bus_addr       (bus_addr),
  .bus_burst      (bus_burst),
  .bus_write      (bus_write),
  .beat_valid     (beat_valid),
  .beat_idx       (beat_idx),
  .beat_cacheable (beat_cacheable),
  .cyc_done       (cyc_done),
  .cyc_retry      (cyc_retry),
  .cyc_error      (cyc_error),
  .burst_split    (burst_split)
);

// File: tb/bus_term_ctrl_tb.sv
module bus_term_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk, rst_n, legacy_ack;
  logic req_valid, req_line, req_write;
  logic [31:0] req_addr, bus_addr;
  logic busy, bus_start, bus_burst, bus_write;
  logic ack_ok, ack_retry, ack_err, ack_noburst, ack_nocache;
  logic beat_valid, beat_cacheable, cyc_done, cyc_retry, cyc_error, burst_split;
  logic [1:0] beat_idx;

  int n_chk = 0;
  int n_fail = 0;

  bus_term_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .legacy_ack(legacy_ack),
    .req_valid(req_valid), .req_line(req_line), .req_write(req_write), .req_addr(req_addr),
    .busy(busy), .bus_start(bus_start), .bus_addr(bus_addr), .bus_burst(bus_burst),
    .bus_write(bus_write), .ack_ok(ack_ok), .ack_retry(ack_retry), .ack_err(ack_err),
    .ack_noburst(ack_noburst), .ack_nocache(ack_nocache), .beat_valid(beat_valid),
    .beat_idx(beat_idx), .beat_cacheable(beat_cacheable), .cyc_done(cyc_done),
    .cyc_retry(cyc_retry), .cyc_error(cyc_error), .burst_split(burst_split)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    report();
    $finish;
  end

  task automatic chk(input bit good, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // v[0]=ok v[1]=retry v[2]=err v[3]=noburst v[4]=nocache
  task automatic set_acks(input logic [4:0] v);
    {ack_nocache, ack_noburst, ack_err, ack_retry, ack_ok} = v;
  endtask

  // 0 wait, 1 accept, 2 retry, 3 error
  function automatic int exp_term(input bit leg, input bit first, input logic [4:0] v);
    if (!leg) begin
      if (v[2]) return 3;
      if (v[1] && first) return 2;
      if (v[0]) return 1;
      return 0;
    end
    if (v[2] && v[0] && first) return 2;
    if (v[2]) return 3;
    if (v[0]) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] follow_addr(input logic [31:0] b, input int k);
    logic [1:0] o;
    o = b[3:2] + 2'(k);
    return {b[31:4], o, b[1:0]};
  endfunction

  task automatic start_req(input bit line, input bit wr, input logic [31:0] a);
    @(negedge clk);
    set_acks(5'b0);
    req_valid = 1'b1; req_line = line; req_write = wr; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(bus_start == 1'b1, "R2", "bus_start", bus_start, 1);
    chk(bus_addr == a, "R2", "bus_addr", bus_addr, a);
    chk(bus_burst == line, "R2", "bus_burst", bus_burst, line);
  endtask

  task automatic expect_addr(input logic [31:0] a, input bit burst, input string tag);
    @(negedge clk);
    set_acks(5'b0);
    #1;
    chk(bus_start == 1'b1, tag, "restart", bus_start, 1);
    chk(bus_addr == a, tag, "bus_addr", bus_addr, a);
    chk(bus_burst == burst, tag, "bus_burst", bus_burst, burst);
  endtask

  task automatic beat(input logic [4:0] v, input int t, input int idx, input bit cache,
                      input bit done, input bit split, input string tag);
    @(negedge clk);
    set_acks(v);
    #1;
    chk({cyc_error, cyc_retry, beat_valid} == {t == 3, t == 2, t == 1}, tag, "outcome",
        {cyc_error, cyc_retry, beat_valid}, {t == 3, t == 2, t == 1});
    if (t == 1) begin
      chk(beat_idx == 2'(idx), "R8", "beat_idx", beat_idx, idx);
      chk(beat_cacheable == cache, "R10", "cacheable", beat_cacheable, cache);
      chk(cyc_done == done, "R8", "done", cyc_done, done);
      chk(burst_split == split, "R9", "split", burst_split, split);
    end else begin
      chk(cyc_done == 1'b0, tag, "done", cyc_done, 0);
      chk(burst_split == 1'b0, "R9", "split", burst_split, 0);
    end
  endtask

  task automatic expect_idle(input string tag);
    @(negedge clk);
    set_acks(5'b0);
    #1;
    chk(busy == 1'b0 && bus_start == 1'b0, tag, "idle", {busy, bus_start}, 0);
  endtask

  // beats 1..3 with retry and nocache asserted; both must be ignored
  task automatic rest_line(input bit cache);
    for (int k = 1; k < 4; k++) beat(5'b10011, 1, k, cache, k == 3, 0, "R4");
  endtask

  task automatic first_sweep(input bit leg, input bit wr, input logic [4:0] v);
    logic [31:0] base;
    int t;
    bit cache;
    base  = 32'h4000_0000 | (32'(v) << 8) | (32'(wr) << 4) | 32'h8;
    t     = exp_term(leg, 1, v);
    cache = !wr && !v[4];
    start_req(1, wr, base);
    beat(v, t, 0, cache, 0, (t == 1) && v[3], t == 0 ? "R11" : (leg ? "R6" : "R3"));
    case (t)
      3: expect_idle("R7");
      2: begin
        expect_addr(base, 1, "R5");
        beat(5'b00001, 1, 0, !wr, 0, 0, "R5");
        rest_line(!wr);
        expect_idle("R8");
      end
      0: begin
        chk(busy == 1'b1, "R11", "busy", busy, 1);
        beat(5'b00001, 1, 0, !wr, 0, 0, "R11");
        rest_line(!wr);
        expect_idle("R8");
      end
      default: begin
        if (v[3]) begin
          for (int k = 1; k < 4; k++) begin
            expect_addr(follow_addr(base, k), 0, "R9");
            beat(5'b11001, 1, k, cache, k == 3, 0, "R9");
          end
        end else begin
          rest_line(cache);
        end
        expect_idle("R8");
      end
    endcase
  endtask

  task automatic later_sweep(input bit leg, input logic [4:0] v);
    logic [31:0] base;
    int t;
    base = 32'h2000_0004 | (32'(v) << 8);
    t    = exp_term(leg, 0, v);
    start_req(1, 0, base);
    beat(5'b00001, 1, 0, 1, 0, 0, "R8");
    beat(v, t, 1, 1, 0, 0, t == 0 ? "R11" : (leg ? "R6" : "R4"));
    if (t == 3) begin
      expect_idle("R7");
    end else begin
      if (t == 0) beat(5'b00001, 1, 1, 1, 0, 0, "R11");
      for (int k = 2; k < 4; k++) beat(5'b00001, 1, k, 1, k == 3, 0, "R8");
      expect_idle("R8");
    end
  endtask

  task automatic single_sweep(input bit leg, input logic [4:0] v);
    logic [31:0] a;
    int t;
    a = 32'h1000_000C | (32'(v) << 8);
    t = exp_term(leg, 1, v);
    start_req(0, v[0], a);
    beat(v, t, 0, 0, 1, 0, t == 0 ? "R11" : (leg ? "R6" : "R3"));
    if (t == 3) begin
      expect_idle("R7");
    end else begin
      if (t == 2) begin
        expect_addr(a, 0, "R5");
        beat(5'b10001, 1, 0, 0, 1, 0, "R5");
      end else if (t == 0) begin
        beat(5'b10001, 1, 0, 0, 1, 0, "R11");
      end
      expect_idle("R8");
    end
  endtask

  initial begin
    rst_n = 1'b0; legacy_ack = 1'b0;
    req_valid = 1'b0; req_line = 1'b0; req_write = 1'b0; req_addr = '0;
    set_acks(5'b0);
    repeat (3) @(negedge clk);
    #1;
    chk({busy, bus_start, beat_valid, cyc_done, cyc_retry, cyc_error, burst_split} == '0,
        "R1", "outputs in reset",
        {busy, bus_start, beat_valid, cyc_done, cyc_retry, cyc_error, burst_split}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk({busy, bus_start, beat_valid, cyc_done, cyc_retry, cyc_error, burst_split} == '0,
        "R1", "outputs after reset",
        {busy, bus_start, beat_valid, cyc_done, cyc_retry, cyc_error, burst_split}, 0);

    for (int m = 0; m < 2; m++) begin
      legacy_ack = 1'(m);
      for (int w = 0; w < 2; w++)
        for (int v = 0; v < 32; v++) first_sweep(1'(m), 1'(w), 5'(v));
      for (int v = 0; v < 32; v++) later_sweep(1'(m), 5'(v));
      for (int v = 0; v < 32; v++) single_sweep(1'(m), 5'(v));
    end

    report();
    $finish;
  end
endmodule